// File: doc/BRIEF.md
# Pin Change Wake and Interrupt Unit

This unit watches a bank of up to 31 input pins and raises an interrupt request when any pin that software has armed moves from one logic level to the other. It keeps a reference copy of the pin levels taken on every clock edge. An armed pin whose live level differs from that copy counts as a change. Rising and falling moves count the same. The interrupt flag is sticky and stays set until a clear strobe removes it.

The comparison against the stored copy is purely combinational, so a change is still seen while the main clock is stopped during sleep. In that state the unit drives a wake request straight from the comparison. When the clock comes back, the first edge sets the flag.

Two registers are written over a small write-only bus: an arm mask and a pull-up mask. Each pin has its own pull-up control output. That output follows the pull-up mask, but it is forced off for any pin whose direction input marks it as an output.

Top module: `cn_notify`

## Requirements
- R1: After reset, irq_o is 0, wake_o is 0, and every bit of pullup_o is 0. The arm mask and the pull-up mask both reset to all zeros.
- R2: A write with wr_en_i=1 loads wr_data_i on the clock edge. When wr_sel_i=0 the data goes into the arm mask, and when wr_sel_i=1 it goes into the pull-up mask. Bit i of either mask belongs to pin i.
- R3: When an armed pin rises, irq_o is 1 after the next clock edge.
- R4: When an armed pin falls, irq_o is 1 after the next clock edge.
- R5: Level changes on pins whose arm bit is 0 never set irq_o and never raise wake_o.
- R6: Once irq_o is set, it stays 1 for as long as flag_clr_i is 0.
- R7: When flag_clr_i is 1 at an edge, irq_o goes to 0 after that edge, unless an armed pin changes in the same cycle, in which case irq_o stays 1.
- R8: One change produces one flag event. A pin that holds its new level after the flag has been cleared does not set the flag again.
- R9: Setting a pin's arm bit from 0 to 1 raises no interrupt and no wake on its own, even when that pin's level moves in the same cycle as the write.
- R10: While the clock is stopped, wake_o is 1 whenever an armed pin differs from the level sampled at the last edge. The first edge after the clock restarts sets irq_o and brings wake_o back to 0.
- R11: pullup_o[i] equals pull-up mask bit i when pin_out_dir_i[i]=0, and is 0 when pin_out_dir_i[i]=1. It changes combinationally with the direction input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; may be stopped in sleep |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 31 | Live pin levels |
| pin_out_dir_i | input | 31 | Per-pin direction, 1 = pin drives as output |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 = arm mask, 1 = pull-up mask |
| wr_data_i | input | 31 | Register write data |
| flag_clr_i | input | 1 | Clears the sticky interrupt flag |
| irq_o | output | 1 | Sticky interrupt request |
| wake_o | output | 1 | Combinational wake request |
| pullup_o | output | 31 | Per-pin pull-up enable |

## Verification
The hardest situation to reach from the ports is a pin change that happens while no clock edge arrives. The bench gates its own clock generator with a run flag. It stops the clock with the clock low, moves an armed pin, and checks that wake_o is high while irq_o still holds its old value. It then restarts the clock and checks, one edge later, that the flag is set and the wake request has dropped. A second awkward case is a pin that changes in the same cycle as the write that arms it. The bench drives both in one cycle and shows that neither output reacts, then toggles the pin again to show that the arm bit did take effect.

// File: rtl/cn_pkg.sv
package cn_pkg;
  typedef enum logic {
    CN_SEL_ARM    = 1'b0,
    CN_SEL_PULLUP = 1'b1
  } cn_sel_e;
endpackage

// File: rtl/cn_regs.sv
module cn_regs
  import cn_pkg::*;
#(
  parameter int N_PINS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [N_PINS-1:0] wr_data_i,
  output logic [N_PINS-1:0] arm_o,
  output logic [N_PINS-1:0] pu_o
);
  cn_sel_e     sel;
  logic        arm_wr;
  logic        pu_wr;

  assign sel    = cn_sel_e'(wr_sel_i);
  assign arm_wr = wr_en_i && (sel == CN_SEL_ARM);
  assign pu_wr  = wr_en_i && (sel == CN_SEL_PULLUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_o <= '0;
      pu_o  <= '0;
    end else begin
      if (arm_wr) arm_o <= wr_data_i;
      if (pu_wr)  pu_o  <= wr_data_i;
    end
  end

  // R2
  arm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> (arm_o == $past(wr_data_i)));

  // R2
  pu_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pu_wr) |=> $stable(pu_o));
endmodule

// File: rtl/cn_change_detect.sv
module cn_change_detect #(
  parameter int N_PINS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] arm_i,
  output logic [N_PINS-1:0] change_o,
  output logic              any_change_o
);
  logic [N_PINS-1:0] snap_q;

  // armed pins whose live level departs from the last sampled level
  function automatic logic [N_PINS-1:0] diff_mask(
    input logic [N_PINS-1:0] live,
    input logic [N_PINS-1:0] ref_lvl,
    input logic [N_PINS-1:0] armed
  );
    return (live ^ ref_lvl) & armed;
  endfunction

  // sampling every edge keeps each change to a single cycle and makes a
  // freshly armed pin start from its current level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= pin_i;
  end

  assign change_o     = diff_mask(pin_i, snap_q, arm_i);
  assign any_change_o = |change_o;

  // R8
  snap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (snap_q == $past(pin_i)));

  // R5
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i == '0) |-> !any_change_o);
endmodule

// File: rtl/cn_sticky_flag.sv
module cn_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // a set in the clearing cycle wins over the clear
  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= next_flag(flag_o, set_i, clr_i);
  end

  // R3
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/cn_notify.sv
module cn_notify #(
  parameter int N_PINS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] pin_out_dir_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [N_PINS-1:0] wr_data_i,
  input  logic              flag_clr_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic [N_PINS-1:0] pullup_o
);
  logic [N_PINS-1:0] arm_q;
  logic [N_PINS-1:0] pu_q;
  logic [N_PINS-1:0] change_vec;
  logic              any_change;

  function automatic logic [N_PINS-1:0] pu_gate(
    input logic [N_PINS-1:0] pu,
    input logic [N_PINS-1:0] drives
  );
    return pu & ~drives;
  endfunction

  cn_regs #(.N_PINS(N_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .arm_o     (arm_q),
    .pu_o      (pu_q)
  );

  cn_change_detect #(.N_PINS(N_PINS)) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_i        (pin_i),
    .arm_i        (arm_q),
    .change_o     (change_vec),
    .any_change_o (any_change)
  );

  cn_sticky_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (any_change),
    .clr_i  (flag_clr_i),
    .flag_o (irq_o)
  );

  assign wake_o   = any_change;
  assign pullup_o = pu_gate(pu_q, pin_out_dir_i);

  // R10
  wake_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> irq_o);

  // R11
  pu_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pu_q) && $stable(pin_out_dir_i) |-> $stable(pullup_o));
endmodule

// File: tb/cn_notify_tb.sv
module cn_notify_tb;
  localparam int N = 31;
  localparam int NV = 15;
  localparam logic [N-1:0] ARM_MASK = 31'h0000_00FF;

  // {pins, clr, expected wake before edge, expected irq after edge}
  localparam logic [N+2:0] VEC [NV] = '{
    {31'h0000_0000, 1'b0, 1'b0, 1'b0},
    {31'h0000_0001, 1'b0, 1'b1, 1'b1},  // R3 rise
    {31'h0000_0003, 1'b1, 1'b1, 1'b1},  // R7 clear loses to change
    {31'h0000_0003, 1'b1, 1'b0, 1'b0},  // R7 clear
    {31'h0000_0003, 1'b0, 1'b0, 1'b0},  // R8 held level
    {31'h0000_0000, 1'b0, 1'b1, 1'b1},  // R4 fall
    {31'h0000_0000, 1'b0, 1'b0, 1'b1},  // R6 sticky
    {31'h0000_0000, 1'b1, 1'b0, 1'b0},
    {31'h0000_0100, 1'b0, 1'b0, 1'b0},  // R5 unarmed rise
    {31'h0000_0100, 1'b0, 1'b0, 1'b0},
    {31'h0000_0180, 1'b0, 1'b1, 1'b1},  // R3 pin7
    {31'h0000_0180, 1'b1, 1'b0, 1'b0},
    {31'h0000_0080, 1'b0, 1'b0, 1'b0},  // R5 unarmed fall
    {31'h7FFF_FF80, 1'b0, 1'b0, 1'b0},  // R5 many unarmed
    {31'h7FFF_FF00, 1'b0, 1'b1, 1'b1}   // R4 pin7 fall
  };

  logic         clk = 1'b0;
  logic         clk_run = 1'b1;
  logic         rst_n;
  logic [N-1:0] pin_i;
  logic [N-1:0] pin_out_dir_i;
  logic         wr_en_i;
  logic         wr_sel_i;
  logic [N-1:0] wr_data_i;
  logic         flag_clr_i;
  logic         irq_o;
  logic         wake_o;
  logic [N-1:0] pullup_o;

  int vectors = 0;
  int miscompares = 0;

  cn_notify #(.N_PINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_out_dir_i(pin_out_dir_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .flag_clr_i(flag_clr_i), .irq_o(irq_o), .wake_o(wake_o), .pullup_o(pullup_o)
  );

  initial forever begin
    #10;
    if (clk_run) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [N-1:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pin_i = '0; pin_out_dir_i = '0; wr_en_i = 1'b0;
    wr_sel_i = 1'b0; wr_data_i = '0; flag_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 wake", {31'b0, wake_o}, 0);
    chk("R1 pullup", {1'b0, pullup_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pullup after release", {1'b0, pullup_o}, 0);

    // R2 / R11: pull-up mask and direction gating
    wr(1'b1, 31'h5555_5555);
    chk("R2 pullup mask", {1'b0, pullup_o}, 32'h5555_5555);
    pin_out_dir_i = 31'h0F0F_0F0F;
    #2;
    chk("R11 dir gating", {1'b0, pullup_o}, 32'h5050_5050);
    pin_out_dir_i = '0;
    #2;
    chk("R11 dir release", {1'b0, pullup_o}, 32'h5555_5555);

    // table walk with pins 0..7 armed
    wr(1'b0, ARM_MASK);
    for (int i = 0; i < NV; i++) begin
      pin_i = VEC[i][N+2:3];
      flag_clr_i = VEC[i][2];
      #5;
      chk($sformatf("vec%0d wake R3/R4/R5/R7/R8", i), {31'b0, wake_o}, {31'b0, VEC[i][1]});
      @(posedge clk);
      #5;
      chk($sformatf("vec%0d irq R3/R4/R6/R7/R8", i), {31'b0, irq_o}, {31'b0, VEC[i][0]});
      @(negedge clk);
    end
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;

    // R9: pin16 moves in the same cycle its arm bit is written
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = ARM_MASK | 31'h0001_0000;
    pin_i = pin_i ^ 31'h0001_0000;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk("R9 no wake on arming", {31'b0, wake_o}, 0);
    @(negedge clk);
    chk("R9 no irq on arming", {31'b0, irq_o}, 0);
    pin_i = pin_i ^ 31'h0001_0000;
    @(negedge clk);
    chk("R9 armed pin now flags", {31'b0, irq_o}, 1);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    chk("R7 cleared before sleep", {31'b0, irq_o}, 0);

    // R10: stop the clock (low), move an armed pin
    clk_run = 1'b0;
    #40;
    pin_i = pin_i ^ 31'h0000_0004;
    #100;
    chk("R10 wake while stopped", {31'b0, wake_o}, 1);
    chk("R10 irq waits for clock", {31'b0, irq_o}, 0);
    clk_run = 1'b1;
    @(posedge clk);
    #5;
    chk("R10 irq after restart", {31'b0, irq_o}, 1);
    chk("R10 wake drops", {31'b0, wake_o}, 0);
    @(negedge clk);
    finish_run();
  end
endmodule